// File: doc/BRIEF.md
# Indirect PHY Parameter Access Port

This block is a memory-mapped register slave that keeps two 32-bit configuration words for a high-speed PHY. It also gives software indirect access to a small bank of 8-bit internal tuning registers. Both configuration words and every bank register are driven out as plain outputs so that the PHY logic can use them directly.

The second configuration word acts as a mailbox. It carries an address-phase strobe in bit 28 and a data-phase strobe in bit 29. A 12-bit register address sits in bits 27:16, and an 8-bit data byte sits in bits 23:16, so the byte shares its position with the low address bits. Software reaches one internal register with four writes to that word:

1. Write the address with the address strobe high.
2. Write again with the address strobe low.
3. Write the byte with the data strobe high.
4. Write again with the data strobe low.

The block watches each write for a 0-to-1 transition of a strobe bit. On an address edge it latches the register index. On a data edge it commits the byte to the latched register. To change only part of a register, software builds the whole byte itself, with the new value shifted to the field's offset and masked to the field's width.

Top module: `phy_param_port`

## Requirements
- R1: After reset, both configuration words, every bank register and the read data are zero.
- R2: A write at byte offset 0x0 replaces configuration word 0, and a write at offset 0x4 replaces configuration word 1. Reading either offset returns all 32 bits last written to it, including the strobe bits 29 and 28 of word 1.
- R3: A write to any offset other than 0x0 and 0x4 changes no configuration word and no bank register. A read of such an offset returns zero.
- R4: When a write to word 1 takes bit 28 from 0 to 1, the block latches that word's bits 19:16 as the register index. Address bits 27:20 are ignored.
- R5: When a write to word 1 takes bit 29 from 0 to 1, and an index is held, bits 23:16 of that word are stored into the indexed bank register. The new value appears on the outputs after the clock edge that takes the write.
- R6: A write to word 1 that leaves bit 29 high changes no bank register. This holds when the bit was already high before the write, and equally when the bit is low in the write.
- R7: A data-strobe edge that arrives when no address edge has occurred since reset changes no bank register.
- R8: When a single write raises both strobes, the index comes from that same word, and the byte is stored at that new index.
- R9: A latched index is kept until the next address-strobe edge, so several data phases in a row reach the same register.
- R10: Writes to word 0 never start an address or data phase, whatever their bits 29 and 28 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte offset for both reads and writes |
| bus_wr | input | 1 | Write enable, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cfg0_o | output | 32 | Configuration word 0 |
| cfg1_o | output | 32 | Configuration word 1 |
| bank_o | output | 128 | Bank registers; register n occupies bits 8n+7:8n |

## Verification
The hardest situation to reach from the ports is a data-strobe edge that the block must refuse because no index has ever been latched. A bench that follows the normal write sequence always sends an address first, so it never produces this case. The bench therefore applies a fresh reset and, as the very first mailbox write, raises only the data strobe with a nonzero byte. It then checks that all sixteen bank registers are still zero. The other refusal cases are a strobe that is written high while already high, and a strobe written with bit 29 low. Both come from writes placed back to back in the stimulus table, and the bench checks that the target register keeps its old value.

// File: rtl/phy_param_pkg.sv
package phy_param_pkg;

  localparam int unsigned WORD_W      = 32;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned OFS_CFG0    = 0;
  localparam int unsigned OFS_CFG1    = 4;
  localparam int unsigned BIT_DSTB    = 29;
  localparam int unsigned BIT_ASTB    = 28;
  localparam int unsigned FIELD_LSB   = 16;

  typedef struct packed {
    logic                  adr_rise;
    logic                  dat_rise;
    logic [BYTE_W-1:0]     byte_val;
    logic [11:0]           adr_val;
  } mbox_evt_t;

endpackage

// File: rtl/cfg_word_regs.sv
module cfg_word_regs
  import phy_param_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [WORD_W-1:0] cfg0_q,
  output logic [WORD_W-1:0] cfg1_q,
  output mbox_evt_t         evt
);

  logic              sel0, sel1;
  logic              en0, en1;
  logic [WORD_W-1:0] cfg0_d, cfg1_d;

  always_comb begin
    sel0 = (bus_addr == ADDR_W'(OFS_CFG0));
    sel1 = (bus_addr == ADDR_W'(OFS_CFG1));
    en0  = bus_wr && sel0;
    en1  = bus_wr && sel1;
    cfg0_d = cfg0_q;
    cfg1_d = cfg1_q;
    if (en0) cfg0_d = bus_wdata;
    if (en1) cfg1_d = bus_wdata;
  end

  always_comb begin
    evt.adr_rise = en1 && bus_wdata[BIT_ASTB] && !cfg1_q[BIT_ASTB];
    evt.dat_rise = en1 && bus_wdata[BIT_DSTB] && !cfg1_q[BIT_DSTB];
    evt.byte_val = bus_wdata[FIELD_LSB +: BYTE_W];
    evt.adr_val  = bus_wdata[FIELD_LSB +: 12];
  end

  always_comb begin
    if (sel0)      bus_rdata = cfg0_q;
    else if (sel1) bus_rdata = cfg1_q;
    else           bus_rdata = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg0_q <= '0;
      cfg1_q <= '0;
    end else begin
      if (en0) cfg0_q <= cfg0_d;
      if (en1) cfg1_q <= cfg1_d;
    end
  end

  // R2 R3: word 1 moves only on a write to its own offset
  a_r3_cfg1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADDR_W'(OFS_CFG1)) |=> $stable(cfg1_q));

  // R2: a write to word 1 is visible in full on the next cycle
  a_r2_cfg1_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_CFG1)) |=> cfg1_q == $past(bus_wdata));

  // R3: word 0 moves only on a write to its own offset
  a_r3_cfg0_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADDR_W'(OFS_CFG0)) |=> $stable(cfg0_q));

endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
  import phy_param_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mbox_evt_t        evt,
  output logic             commit,
  output logic [IDX_W-1:0] commit_idx,
  output logic             idx_valid_q
);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             valid_d;

  always_comb begin
    idx_d   = idx_q;
    valid_d = idx_valid_q;
    if (evt.adr_rise) begin
      idx_d   = evt.adr_val[IDX_W-1:0];
      valid_d = 1'b1;
    end
    commit     = evt.dat_rise && valid_d;
    commit_idx = idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q       <= '0;
      idx_valid_q <= 1'b0;
    end else if (evt.adr_rise) begin
      idx_q       <= idx_d;
      idx_valid_q <= valid_d;
    end
  end

  // R4: the index follows the low address bits of the word that raised the strobe
  a_r4_latch: assert property (@(posedge clk) disable iff (!rst_n)
    evt.adr_rise |=> idx_q == $past(evt.adr_val[IDX_W-1:0]));

  // R9: the index holds until the next address edge
  a_r9_hold_idx: assert property (@(posedge clk) disable iff (!rst_n)
    !evt.adr_rise |=> $stable(idx_q));

  // R7: no address edge yet means no commit
  a_r7_no_index: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_valid_q && !evt.adr_rise) |-> !commit);

endmodule

// File: rtl/param_bank.sv
module param_bank
  import phy_param_pkg::*;
#(
  parameter int unsigned NREG = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(NREG)-1:0]  wr_idx,
  input  logic [BYTE_W-1:0]        wr_byte,
  output logic [NREG*BYTE_W-1:0]   bank_flat
);

  localparam int unsigned IDX_W = $clog2(NREG);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic              hit;
    logic [BYTE_W-1:0] q, d;

    always_comb begin
      hit = wr_en && (wr_idx == IDX_W'(i));
      d   = hit ? wr_byte : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= d;
    end

    assign bank_flat[i*BYTE_W +: BYTE_W] = q;
  end

endmodule

// File: rtl/phy_param_port.sv
module phy_param_port
  import phy_param_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NREG   = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_wr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic [31:0]            cfg0_o,
  output logic [31:0]            cfg1_o,
  output logic [NREG*8-1:0]      bank_o
);

  localparam int unsigned IDX_W = $clog2(NREG);

  mbox_evt_t        evt;
  logic             commit;
  logic [IDX_W-1:0] commit_idx;
  logic             idx_valid;

  cfg_word_regs #(.ADDR_W(ADDR_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg0_q    (cfg0_o),
    .cfg1_q    (cfg1_o),
    .evt       (evt)
  );

  strobe_seq #(.IDX_W(IDX_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt         (evt),
    .commit      (commit),
    .commit_idx  (commit_idx),
    .idx_valid_q (idx_valid)
  );

  param_bank #(.NREG(NREG)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (commit),
    .wr_idx    (commit_idx),
    .wr_byte   (evt.byte_val),
    .bank_flat (bank_o)
  );

  // R6: without a data edge the bank keeps its contents
  a_r6_bank_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !evt.dat_rise |=> $stable(bank_o));

  // R7: a data edge with no index ever latched leaves the bank unchanged
  a_r7_bank_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.dat_rise && !evt.adr_rise && !idx_valid) |=> $stable(bank_o));

  // R10: writes to word 0 start no phase
  a_r10_cfg0_no_evt: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_CFG0)) |-> !(evt.adr_rise || evt.dat_rise));

endmodule

// File: tb/sim_phy_param_port.sv
module sim_phy_param_port;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   bus_addr;
  logic         bus_wr;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata, cfg0_o, cfg1_o;
  logic [127:0] bank_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  phy_param_port u0 (.*);

  // {offset, write word, register checked, expected byte}
  localparam int NV = 16;
  localparam logic [47:0] VEC [NV] = '{
    {4'h4, 32'h1003_0000, 4'h3, 8'h00},   // R4 address edge, index 3
    {4'h4, 32'h0003_0000, 4'h3, 8'h00},
    {4'h4, 32'h20A5_0000, 4'h3, 8'hA5},   // R5 data to index 3, not 5
    {4'h4, 32'h0000_0000, 4'h3, 8'hA5},
    {4'h4, 32'h2077_0000, 4'h3, 8'h77},   // R9 index kept
    {4'h4, 32'h2011_0000, 4'h3, 8'h77},   // R6 strobe already high
    {4'h4, 32'h0022_0000, 4'h3, 8'h77},   // R6 strobe low
    {4'h4, 32'h1FFC_0000, 4'hC, 8'h00},   // R4 upper address bits ignored
    {4'h4, 32'h0FFC_0000, 4'hC, 8'h00},
    {4'h4, 32'h2020_0000, 4'hC, 8'h20},   // R5 index C
    {4'h4, 32'h0000_0000, 4'hC, 8'h20},
    {4'h4, 32'h304E_0000, 4'hE, 8'h4E},   // R8 both strobes in one write
    {4'h4, 32'h0000_0000, 4'hE, 8'h4E},
    {4'h0, 32'h3FF1_0000, 4'hE, 8'h4E},   // R10 word 0 strobe bits
    {4'h8, 32'h3099_0000, 4'h9, 8'h00},   // R3 unmapped offset
    {4'h4, 32'h0000_0000, 4'h3, 8'h77}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_reset();
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    chk("R1 cfg0", cfg0_o, 32'h0);
    chk("R1 cfg1", cfg1_o, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    for (int i = 0; i < 4; i++) chk("R1 bank", bank_o[i*32 +: 32], 32'h0);

    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][47:44], VEC[v][43:12]);
      chk("R4-R10 table", {24'h0, bank_o[VEC[v][11:8]*8 +: 8]}, {24'h0, VEC[v][7:0]});
    end
    chk("R3 bank9 untouched", {24'h0, bank_o[9*8 +: 8]}, 32'h0);

    wr(4'h0, 32'h9231_6680);
    bus_addr = 4'h0; #1;
    chk("R2 word0 readback", bus_rdata, 32'h9231_6680);
    wr(4'h4, 32'h3ABC_0106);
    bus_addr = 4'h4; #1;
    chk("R2 word1 readback", bus_rdata, 32'h3ABC_0106);
    chk("R2 cfg1 port", cfg1_o, 32'h3ABC_0106);
    wr(4'hC, 32'hFFFF_FFFF);
    bus_addr = 4'hC; #1;
    chk("R3 unmapped read", bus_rdata, 32'h0);
    chk("R3 word0 kept", cfg0_o, 32'h9231_6680);
    chk("R3 word1 kept", cfg1_o, 32'h3ABC_0106);

    do_reset();
    wr(4'h4, 32'h2055_0000);
    chk("R7 no index lo", bank_o[63:0], 32'h0);
    chk("R7 no index hi", bank_o[127:64], 32'h0);
    for (int i = 0; i < 4; i++) chk("R7 bank words", bank_o[i*32 +: 32], 32'h0);
    wr(4'h4, 32'h0000_0000);
    wr(4'h4, 32'h1001_0000);
    wr(4'h4, 32'h0000_0000);
    wr(4'h4, 32'h20C3_0000);
    chk("R5 after recovery", {24'h0, bank_o[15:8]}, 32'h0000_00C3);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule